// File: doc/BRIEF.md
# External Interrupt Edge Capture Unit

This unit watches seven external interrupt request pins and turns qualifying changes on them into latched request flags. Each pin first passes through a two-flop synchroniser. The synchronised value is then captured only on a machine-cycle strobe. An edge is recognised when two consecutive strobe samples show the old level and then the new level. Anything that happens between strobes and reverts before the next strobe is not seen.

Sources 2 and 3 take their trigger direction (rising or falling) from software-written type bits. Sources 4, 5 and 6 always trigger on a falling edge. The two legacy sources 0 and 1 trigger on a falling edge, or they can be put into level mode: there the sampled low level drives the request directly and no flag is latched.

An 8-bit register port exposes the flags of sources 2 to 6 and the two type bits. The requesting logic sees a flag only when its enable bit is also set. When the controller acknowledges a vector, the flag of that source is cleared.

Top module: `xint_capture`

## Requirements
- R1: After reset the register reads 8'h00 and every bit of `req_o` is 0. The captured samples reset to high, so pins that are held high through reset raise no flag at the first strobe.
- R2: Register layout: bit 7 always reads 0 and ignores writes; bit i (i = 2..6) is the flag of source i; bit 1 is the type bit of source 3; bit 0 is the type bit of source 2. A write loads all seven implemented bits, so software can set or clear any flag of sources 2 to 6.
- R3: For sources 2 and 3, a type bit of 1 sets the flag on a low-to-high change between consecutive strobe samples. A type bit of 0 sets it on a high-to-low change. The opposite direction leaves the flag untouched.
- R4: Sources 4, 5 and 6 set their flags only on a high-to-low change. Sources 0 and 1 do the same while their mode bit in `lvl_mode_i` is 0.
- R5: Pins are looked at only when `mc_stb` is 1. A low pulse that starts and ends between two strobes sets no flag, and no flag is set while `mc_stb` stays 0.
- R6: A cycle with `ack_valid` = 1 clears the flag of the source numbered `ack_id` (0..6) on the next clock. Other flags keep their values.
- R7: A hardware set in a cycle wins over an acknowledge clear of the same flag in that cycle. It also wins over a register write of 0 to that flag in that cycle.
- R8: While `lvl_mode_i[k]` = 1 (k = 0, 1), `req_o[k]` equals the inverse of the most recent strobe sample of pin k, gated by `en_i[k]`. No flag is latched and an acknowledge has no effect on it.
- R9: `req_o[i]` is 1 only when source i has its flag set (or, in level mode, its pin is sampled low) and `en_i[i]` is 1. The flag itself is kept while the enable is 0.
- R10: A pin change that is held for at least two clocks before a strobe is captured by that strobe. The flag is visible on the clock after the strobe cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_stb | input | 1 | One-cycle pulse marking each machine cycle |
| pin_i | input | 7 | Raw external request pins, source i on bit i |
| lvl_mode_i | input | 2 | Level-mode select for sources 0 and 1 |
| en_i | input | 7 | Per-source request enables |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| ack_valid | input | 1 | Vector acknowledge |
| ack_id | input | 3 | Number of the source being acknowledged |
| req_o | output | 7 | Enabled requests to the interrupt controller |

## Verification
The assertions check on every cycle that a flag rises only in a strobe or write cycle, that flags and samples hold between strobes, that an acknowledge clears its flag unless a set collides with it, that a hardware set always lands, and that level-mode sources never latch. Only the bench's scenarios can show the behaviours that depend on what the pins did: the direction each type bit selects, the fixed falling edges, a short pulse being lost between strobes, the register bit layout, and the level-mode request that follows the pin while acknowledges are ignored.

// File: rtl/xint_pkg.sv
package xint_pkg;
    localparam int NSRC   = 7;
    localparam int LEG    = 2;
    localparam int POL    = 2;
    localparam int REG_W  = 8;
    localparam int ID_W   = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0] flg;
        logic [POL-1:0]  typ;
    } xint_state_t;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xint_sampler.sv
module xint_sampler #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mc_stb,
    input  logic [W-1:0] sync_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] cur_d, cur_q;

    always_comb begin
        cur_d  = cur_q;
        rise_o = '0;
        fall_o = '0;
        if (mc_stb) begin
            cur_d  = sync_i;
            rise_o = ~cur_q & sync_i;
            fall_o = cur_q & ~sync_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '1;
        else        cur_q <= cur_d;
    end

    assign cur_o = cur_q;

    // R5: the sample register moves only on a strobe
    a_r5_sample_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_stb |=> $stable(cur_q));
endmodule

// File: rtl/xint_flags.sv
module xint_flags
    import xint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_stb,
    input  logic [NSRC-1:0]  set_i,
    input  logic [LEG-1:0]   lvl_i,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_id,
    output logic [NSRC-1:0]  flg_o,
    output logic [POL-1:0]   typ_o,
    output logic [REG_W-1:0] rdata_o
);
    xint_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // acknowledge clear has the lowest priority
        if (ack_valid) begin
            for (int i = 0; i < NSRC; i++) begin
                if (ack_id == ID_W'(i)) s_d.flg[i] = 1'b0;
            end
        end
        if (wr_i) begin
            s_d.typ = wdata_i[POL-1:0];
            for (int i = LEG; i < NSRC; i++) begin
                s_d.flg[i] = wdata_i[i - LEG + POL];
            end
        end
        // hardware set wins over both
        s_d.flg = s_d.flg | set_i;
        for (int k = 0; k < LEG; k++) begin
            if (lvl_i[k]) s_d.flg[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[POL-1:0] = s_q.typ;
        for (int i = LEG; i < NSRC; i++) begin
            rdata_o[i - LEG + POL] = s_q.flg[i];
        end
    end

    assign flg_o = s_q.flg;
    assign typ_o = s_q.typ;

    // R2/R5: nothing moves without a strobe, write or acknowledge
    a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_stb && !wr_i && !ack_valid && !(|lvl_i)) |=> $stable(s_q.flg));

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        localparam bit WRITABLE = (i >= LEG);
        // R5: a flag rises only in a strobe or write cycle
        a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(s_q.flg[i]) |-> ($past(mc_stb) || $past(wr_i)));
        // R6: acknowledge clears when nothing else touches the flag
        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_valid && ack_id == ID_W'(i) && !set_i[i] && !(wr_i && WRITABLE))
            |=> !s_q.flg[i]);
        // R7: a hardware set always lands
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> s_q.flg[i]);
    end

    for (genvar k = 0; k < LEG; k++) begin : g_lvl
        // R8: level-mode sources never hold a latched flag
        a_r8_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_i[k] |=> !s_q.flg[k]);
    end
endmodule

// File: rtl/xint_capture.sv
module xint_capture
    import xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_stb,
    input  logic [NSRC-1:0]  pin_i,
    input  logic [LEG-1:0]   lvl_mode_i,
    input  logic [NSRC-1:0]  en_i,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ack_valid,
    input  logic [ID_W-1:0]  ack_id,
    output logic [NSRC-1:0]  req_o
);
    logic [NSRC-1:0] sync_w, cur_w, rise_w, fall_w, set_w, flg_w;
    logic [POL-1:0]  typ_w;

    xint_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (sync_w)
    );

    xint_sampler #(.W(NSRC)) u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .mc_stb (mc_stb),
        .sync_i (sync_w),
        .cur_o  (cur_w),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (i < LEG) begin : g_legacy
            assign set_w[i] = fall_w[i] & ~lvl_mode_i[i];
            assign req_o[i] = en_i[i] & (lvl_mode_i[i] ? ~cur_w[i] : flg_w[i]);
        end else if (i < LEG + POL) begin : g_pol
            assign set_w[i] = typ_w[i - LEG] ? rise_w[i] : fall_w[i];
            assign req_o[i] = en_i[i] & flg_w[i];
        end else begin : g_fixed
            assign set_w[i] = fall_w[i];
            assign req_o[i] = en_i[i] & flg_w[i];
        end
        // R9: no request without its enable
        a_r9_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            req_o[i] |-> en_i[i]);
    end

    xint_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_stb    (mc_stb),
        .set_i     (set_w),
        .lvl_i     (lvl_mode_i),
        .wr_i      (reg_wr),
        .wdata_i   (reg_wdata),
        .ack_valid (ack_valid),
        .ack_id    (ack_id),
        .flg_o     (flg_w),
        .typ_o     (typ_w),
        .rdata_o   (reg_rdata)
    );
endmodule

// File: tb/tb_xint_capture.sv
module tb_xint_capture;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_stb = 1'b0;
    logic [6:0] pin_i = 7'h7F;
    logic [1:0] lvl_mode_i = 2'b00;
    logic [6:0] en_i = 7'h7F;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_id = 3'd0;
    logic [6:0] req_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xint_capture dut (
        .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .pin_i(pin_i),
        .lvl_mode_i(lvl_mode_i), .en_i(en_i), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid),
        .ack_id(ack_id), .req_o(req_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    // one strobe cycle, optionally with an acknowledge and/or write in it
    task automatic strobe(bit ack = 0, logic [2:0] id = 0, bit wr = 0, logic [7:0] wd = 0);
        @(negedge clk);
        mc_stb = 1'b1; ack_valid = ack; ack_id = id; reg_wr = wr; reg_wdata = wd;
        @(negedge clk);
        mc_stb = 1'b0; ack_valid = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic wr_reg(logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic ack(logic [2:0] id);
        @(negedge clk); ack_valid = 1'b1; ack_id = id;
        @(negedge clk); ack_valid = 1'b0;
    endtask

    // R10: change held two clocks before the strobe is captured
    task automatic pin_sample(int idx, bit v);
        @(negedge clk); pin_i[idx] = v;
        ticks(2);
        strobe();
    endtask

    task automatic t_reset;
        chk("R1 reset rdata", reg_rdata, 8'h00);
        chk("R1 reset req", req_o, 7'h00);
        ticks(3); strobe();
        chk("R1 no flag at first strobe", req_o, 7'h00);
    endtask

    task automatic t_register;
        wr_reg(8'hFF);
        chk("R2 reserved bit reads 0", reg_rdata, 8'h7F);
        chk("R2 sw set flags", req_o, 7'h7C);
        wr_reg(8'h00);
        chk("R2 sw clear", reg_rdata, 8'h00);
    endtask

    task automatic t_polarity;
        wr_reg(8'h01);               // src2 rising, src3 falling
        @(negedge clk); pin_i[2] = 0; pin_i[3] = 0;
        ticks(2); strobe();
        chk("R3 falling sets src3 only", reg_rdata, 8'h09);
        @(negedge clk); pin_i[2] = 1; pin_i[3] = 1;
        ticks(2); strobe();
        chk("R3 rising sets src2", reg_rdata, 8'h0D);
        wr_reg(8'h02);               // src2 falling, src3 rising
        pin_sample(3, 0);
        chk("R3 src3 ignores fall when rising", reg_rdata, 8'h02);
        pin_sample(3, 1);
        chk("R3 src3 rising", reg_rdata, 8'h0A);
        wr_reg(8'h00);
    endtask

    task automatic t_fixed;
        pin_sample(5, 0);
        chk("R4 src5 falls", reg_rdata, 8'h20);
        wr_reg(8'h00);
        pin_sample(5, 1);
        chk("R4 src5 ignores rise", reg_rdata, 8'h00);
        pin_sample(0, 0);
        chk("R4 legacy edge falls", req_o, 7'h01);
        pin_sample(0, 1);
        chk("R4 legacy ignores rise", req_o, 7'h01);
        ack(3'd0);
        chk("R6 ack clears legacy", req_o, 7'h00);
    endtask

    task automatic t_short_pulse;
        @(negedge clk); pin_i[6] = 0;
        ticks(3);
        pin_i[6] = 1;
        ticks(3); strobe();
        chk("R5 short pulse lost", req_o, 7'h00);
        @(negedge clk); pin_i[4] = 0;
        ticks(10);
        chk("R5 no strobe no flag", req_o, 7'h00);
        strobe();
        chk("R10 flag after strobe", reg_rdata, 8'h10);
    endtask

    task automatic t_ack;
        pin_sample(5, 0);
        chk("R6 two flags", reg_rdata, 8'h30);
        ack(3'd4);
        chk("R6 ack clears only src4", reg_rdata, 8'h20);
        ack(3'd5);
        chk("R6 ack src5", reg_rdata, 8'h00);
        @(negedge clk); pin_i[4] = 1; pin_i[5] = 1;
        ticks(2); strobe();
    endtask

    task automatic t_priority;
        @(negedge clk); pin_i[6] = 0;
        ticks(2); strobe(1'b1, 3'd6);
        chk("R7 set beats ack", reg_rdata, 8'h40);
        ack(3'd6);
        @(negedge clk); pin_i[6] = 1;
        ticks(2); strobe();
        @(negedge clk); pin_i[6] = 0;
        ticks(2); strobe(1'b0, 3'd0, 1'b1, 8'h00);
        chk("R7 set beats write", reg_rdata, 8'h40);
        wr_reg(8'h00);
        pin_sample(6, 1);
    endtask

    task automatic t_level;
        lvl_mode_i = 2'b10;
        pin_sample(1, 0);
        chk("R8 level req follows low pin", req_o, 7'h02);
        ack(3'd1);
        chk("R8 ack has no effect", req_o, 7'h02);
        en_i[1] = 0; ticks(1);
        chk("R8 level gated by enable", req_o, 7'h00);
        en_i[1] = 1;
        pin_sample(1, 1);
        chk("R8 level drops with pin", req_o, 7'h00);
        lvl_mode_i = 2'b00;
    endtask

    task automatic t_enable;
        pin_sample(5, 0);
        en_i[5] = 0; ticks(1);
        chk("R9 disabled req", req_o, 7'h00);
        chk("R9 flag kept", reg_rdata, 8'h20);
        en_i[5] = 1; ticks(1);
        chk("R9 enabled req", req_o, 7'h20);
        wr_reg(8'h00);
        pin_sample(5, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register();
        t_polarity();
        t_fixed();
        t_short_pulse();
        t_ack();
        t_priority();
        t_level();
        t_enable();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule